// File: doc/BRIEF.md
# Calendar Snapshot Register File with Time-Set Lock

This block sits between a bit-serial host engine and a running calendar counter. It holds ten byte-wide locations that the host reaches by a 4-bit address. Location 0 carries control bits. Location 1 carries read-only change flags. Locations 2 to 9 carry a frozen copy of the eight calendar fields: seconds, minutes, hours, day of month, month, year, weekday and week number.

The host engine issues two commands. A snapshot command (code 0xF) freezes the live calendar into locations 2 to 9. It also records in location 1 which fields moved since the previous snapshot. A clock-load command (code 0xE) hands locations 2 to 9 to the calendar as its new value and clears the change flags. The clock-load command is refused while the time-set lock bit is set.

The control bits leave the block as four registered outputs: frequency-measure enable, two test-mode selects and the lock.

Top module: `snapreg_file`

## Requirements
- R1: A synchronous reset clears locations 0 and 1, the four control outputs and `cal_load`. After reset, reads of locations 0 and 1 return 0.
- R2: A write to location 0 stores the following bits, and each drives the output named beside it:
  - bit 0 drives `freq_meas_en`
  - bit 2 drives `test_mode0`
  - bit 3 drives `test_mode1`
  - bit 4 drives `time_lock`

  Bits 1, 5, 6 and 7 always read back 0.
- R3: Location 1 is read-only. A write to it leaves its contents unchanged.
- R4: Command code 0xF copies the live calendar into locations 2 to 9. Field i, taken from `cal_live[8*i+7:8*i]`, goes to location i+2, in the order seconds, minutes, hours, day of month, month, year, weekday, week number.
- R5: Command 0xF sets bit i of location 1 when field i differs from the value captured at the previous 0xF command, and clears it otherwise. Before the first capture, that previous value is 0.
- R6: Between 0xF commands, locations 2 to 9 keep their captured values while `cal_live` changes.
- R7: A write to locations 2 to 9 changes only the stored byte. It never raises `cal_load`.
- R8: Command 0xE with the lock clear raises `cal_load` for exactly one cycle, in the cycle after the command. In that same cycle, `cal_load_data` carries locations 2 to 9 packed in the R4 order, and location 1 becomes 0.
- R9: Command 0xE with `time_lock` set leaves `cal_load` low and location 1 unchanged.
- R10: A read sets `rd_valid` and `rd_data` one cycle after `rd_en`. Locations 10 to 15 read as 0. Command codes other than 0xE and 0xF have no effect.
- R11: When `cmd_valid` and `wr_en` are high in the same cycle, the command takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Location for a read or write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | Read byte valid |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (0xE load clock, 0xF snapshot) |
| cal_live | input | 64 | Live calendar fields, field i at bits 8i+7:8i |
| cal_load | output | 1 | One-cycle load strobe toward the calendar |
| cal_load_data | output | 64 | Fields to load, same packing as cal_live |
| freq_meas_en | output | 1 | Frequency-measure enable |
| test_mode0 | output | 1 | Test mode select 0 |
| test_mode1 | output | 1 | Test mode select 1 |
| time_lock | output | 1 | Time-set lock |

## Verification
The assertions assume two things about the inputs. First, the host engine drives `cmd_valid`, `cmd_code` and `rd_en` to known values from the first clock edge. Second, a clock-load command is judged against the lock value already registered when the command arrives. The bench keeps within both. It holds every strobe low through reset, changes inputs only on falling edges, and always sets the lock with a separate write before any 0xE command that depends on it.

// File: rtl/snapreg_pkg.sv
package snapreg_pkg;
  localparam logic [3:0] CMD_LOAD_CLOCK = 4'hE;
  localparam logic [3:0] CMD_SNAPSHOT   = 4'hF;

  localparam int LOC_CTRL   = 0;
  localparam int LOC_FLAGS  = 1;
  localparam int FIELD_BASE = 2;

  localparam int CB_FREQ = 0;
  localparam int CB_TM0  = 2;
  localparam int CB_TM1  = 3;
  localparam int CB_LOCK = 4;

  localparam logic [7:0] CTRL_KEEP_MASK = 8'h1D;
endpackage

// File: rtl/snap_ctrl_reg.sv
module snap_ctrl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q
);
  import snapreg_pkg::*;
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP_MASK);

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_stb) ctrl_q <= wr_data & KEEP;
  end
endmodule

// File: rtl/snap_field_bank.sv
module snap_field_bank #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_FIELDS-1:0]         wr_sel,
  input  logic [FIELD_W-1:0]            wr_data,
  input  logic                          snap_stb,
  input  logic                          load_stb,
  input  logic [NUM_FIELDS*FIELD_W-1:0] live_flat,
  output logic [NUM_FIELDS*FIELD_W-1:0] held_flat,
  output logic [NUM_FIELDS-1:0]         chg_flags
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [FIELD_W-1:0] held_q;
    logic [FIELD_W-1:0] prev_q;
    logic               flag_q;
    logic [FIELD_W-1:0] live_v;

    assign live_v = live_flat[g*FIELD_W +: FIELD_W];

    // held byte: snapshot beats a host write
    always_ff @(posedge clk) begin
      if (rst) begin
        held_q <= '0;
        prev_q <= '0;
      end else if (snap_stb) begin
        held_q <= live_v;
        prev_q <= live_v;
      end else if (wr_sel[g]) begin
        held_q <= wr_data;
      end
    end

    // change flag against the previous capture
    always_ff @(posedge clk) begin
      if (rst)           flag_q <= 1'b0;
      else if (snap_stb) flag_q <= (live_v != prev_q);
      else if (load_stb) flag_q <= 1'b0;
    end

    assign held_flat[g*FIELD_W +: FIELD_W] = held_q;
    assign chg_flags[g] = flag_q;
  end
endmodule

// File: rtl/snap_read_port.sv
module snap_read_port #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 8,
  parameter int ADDR_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [FIELD_W-1:0]            ctrl_byte,
  input  logic [FIELD_W-1:0]            flags_byte,
  input  logic [NUM_FIELDS*FIELD_W-1:0] held_flat,
  output logic [FIELD_W-1:0]            rd_data,
  output logic                          rd_valid
);
  import snapreg_pkg::*;
  logic [FIELD_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_addr == ADDR_W'(LOC_CTRL))       sel = ctrl_byte;
    else if (rd_addr == ADDR_W'(LOC_FLAGS)) sel = flags_byte;
    else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (rd_addr == ADDR_W'(FIELD_BASE + i)) sel = held_flat[i*FIELD_W +: FIELD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/snapreg_file.sv
module snapreg_file #(
  parameter int ADDR_W     = 4,
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          wr_en,
  input  logic [FIELD_W-1:0]            wr_data,
  input  logic                          rd_en,
  output logic [FIELD_W-1:0]            rd_data,
  output logic                          rd_valid,
  input  logic                          cmd_valid,
  input  logic [3:0]                    cmd_code,
  input  logic [NUM_FIELDS*FIELD_W-1:0] cal_live,
  output logic                          cal_load,
  output logic [NUM_FIELDS*FIELD_W-1:0] cal_load_data,
  output logic                          freq_meas_en,
  output logic                          test_mode0,
  output logic                          test_mode1,
  output logic                          time_lock
);
  import snapreg_pkg::*;
  localparam int CAL_W = NUM_FIELDS * FIELD_W;

  logic                  wr_ok;
  logic                  ctrl_wr;
  logic [NUM_FIELDS-1:0] field_sel;
  logic                  snap_stb;
  logic                  load_stb;
  logic [FIELD_W-1:0]    ctrl_q;
  logic [CAL_W-1:0]      held_flat;
  logic [NUM_FIELDS-1:0] chg_flags;
  logic [FIELD_W-1:0]    flags_byte;

  // R11: any command drops a same-cycle write
  assign wr_ok    = wr_en && !cmd_valid;
  assign ctrl_wr  = wr_ok && (reg_addr == ADDR_W'(LOC_CTRL));
  assign snap_stb = cmd_valid && (cmd_code == CMD_SNAPSHOT);
  assign load_stb = cmd_valid && (cmd_code == CMD_LOAD_CLOCK) && !ctrl_q[CB_LOCK];

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++)
      field_sel[i] = wr_ok && (reg_addr == ADDR_W'(FIELD_BASE + i));
  end

  assign flags_byte = FIELD_W'(chg_flags);

  snap_ctrl_reg #(.DATA_W(FIELD_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_stb(ctrl_wr), .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  snap_field_bank #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) bank_i (
    .clk(clk), .rst(rst), .wr_sel(field_sel), .wr_data(wr_data),
    .snap_stb(snap_stb), .load_stb(load_stb), .live_flat(cal_live),
    .held_flat(held_flat), .chg_flags(chg_flags)
  );

  snap_read_port #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) rdp_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(reg_addr),
    .ctrl_byte(ctrl_q), .flags_byte(flags_byte), .held_flat(held_flat),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_load      <= 1'b0;
      cal_load_data <= '0;
    end else begin
      cal_load <= load_stb;
      if (load_stb) cal_load_data <= held_flat;
    end
  end

  assign freq_meas_en = ctrl_q[CB_FREQ];
  assign test_mode0   = ctrl_q[CB_TM0];
  assign test_mode1   = ctrl_q[CB_TM1];
  assign time_lock    = ctrl_q[CB_LOCK];
endmodule

// File: rtl/snapreg_file_chk.sv
module snapreg_file_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       cal_load,
  input logic       freq_meas_en,
  input logic       test_mode0,
  input logic       test_mode1,
  input logic       time_lock
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!freq_meas_en && !test_mode0 && !test_mode1 && !time_lock && !cal_load));

  a_r8_load_when_unlocked: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 4'hE && !time_lock) |=> cal_load);

  a_r9_lock_blocks_load: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 4'hE && time_lock) |=> !cal_load);

  a_r7_load_only_by_cmd: assert property (@(posedge clk) disable iff (rst)
    cal_load |-> $past(cmd_valid && cmd_code == 4'hE));

  a_r10_read_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r10_no_spurious_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

bind snapreg_file snapreg_file_chk chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cal_load(cal_load),
  .freq_meas_en(freq_meas_en), .test_mode0(test_mode0),
  .test_mode1(test_mode1), .time_lock(time_lock)
);

// File: tb/snapreg_file_tb_top.sv
`timescale 1ns/1ps
module snapreg_file_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic [63:0] cal_live = '0;
  logic        cal_load;
  logic [63:0] cal_load_data;
  logic        freq_meas_en, test_mode0, test_mode1, time_lock;

  always #5 clk = ~clk;

  snapreg_file dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_field [8];
  logic [7:0] m_prev  [8];
  logic [7:0] m_flags = '0;
  logic [7:0] m_ctrl  = '0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(logic [3:0] a);
    if (a == 4'd0) return m_ctrl;
    if (a == 4'd1) return m_flags;
    if (a >= 4'd2 && a <= 4'd9) return m_field[a - 4'd2];
    return 8'h00;
  endfunction

  function automatic logic [63:0] model_pack();
    logic [63:0] p;
    for (int i = 0; i < 8; i++) p[i*8 +: 8] = m_field[i];
    return p;
  endfunction

  // monitor: pops expected bytes as reads complete
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk("R10 read without request", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {56'd0, rd_data}, {56'd0, e});
      end
    end
  end

  task automatic rd(logic [3:0] a, string tag);
    @(negedge clk);
    rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 4'd0) m_ctrl = d & 8'h1D;
    else if (a >= 4'd2 && a <= 4'd9) m_field[a - 4'd2] = d;
    chk("R7 register write raised cal_load", {63'd0, cal_load}, 64'd0);
  endtask

  task automatic model_cmd(logic [3:0] c, output logic exp_load);
    exp_load = 1'b0;
    if (c == 4'hF) begin
      for (int i = 0; i < 8; i++) begin
        m_flags[i] = (cal_live[i*8 +: 8] != m_prev[i]);
        m_prev[i]  = cal_live[i*8 +: 8];
        m_field[i] = cal_live[i*8 +: 8];
      end
    end else if (c == 4'hE && !m_ctrl[4]) begin
      exp_load = 1'b1;
      m_flags  = '0;
    end
  endtask

  task automatic cmd(logic [3:0] c, logic with_wr, logic [3:0] a, logic [7:0] d);
    logic el;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    wr_en = with_wr; reg_addr = a; wr_data = d;
    model_cmd(c, el);
    @(negedge clk);
    cmd_valid = 1'b0; wr_en = 1'b0;
    if (c == 4'hE && m_ctrl[4])
      chk("R9 locked load raised cal_load", {63'd0, cal_load}, 64'd0);
    else
      chk("R8 cal_load pulse", {63'd0, cal_load}, {63'd0, el});
    if (el) begin
      chk("R8 cal_load_data", cal_load_data, model_pack());
      @(negedge clk);
      chk("R8 cal_load single cycle", {63'd0, cal_load}, 64'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_field[i] = '0; m_prev[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 control outputs after reset",
        {60'd0, freq_meas_en, test_mode0, test_mode1, time_lock}, 64'd0);
    chk("R1 cal_load after reset", {63'd0, cal_load}, 64'd0);
    rd(4'd0, "R1 location 0 after reset");
    rd(4'd1, "R1 location 1 after reset");

    wr(4'd0, 8'hFF);
    chk("R2 control outputs", {60'd0, freq_meas_en, test_mode0, test_mode1, time_lock}, 64'hF);
    rd(4'd0, "R2 reserved bits read 0");
    wr(4'd0, 8'h05);
    chk("R2 freq and tm0 only", {60'd0, freq_meas_en, test_mode0, test_mode1, time_lock}, 64'hC);
    wr(4'd0, 8'h00);

    cal_live = 64'h0112_0311_2315_4530;
    cmd(4'hF, 1'b0, 4'd0, 8'h00);
    for (int i = 0; i < 8; i++) rd(4'(i + 2), "R4 snapshot field");
    rd(4'd1, "R5 flags after first capture");

    wr(4'd1, 8'hAA);
    rd(4'd1, "R3 location 1 write ignored");

    cal_live = 64'h0112_0311_2315_4632;
    cmd(4'hF, 1'b0, 4'd0, 8'h00);
    rd(4'd1, "R5 seconds and minutes changed");
    cmd(4'hF, 1'b0, 4'd0, 8'h00);
    rd(4'd1, "R5 nothing changed");

    cal_live = 64'h2205_1299_3123_5959;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) rd(4'(i + 2), "R6 snapshot held");

    wr(4'd4, 8'h42);
    rd(4'd4, "R7 stored byte written");
    cmd(4'hF, 1'b0, 4'd0, 8'h00);
    rd(4'd1, "R5 flags after live change");
    rd(4'd4, "R4 snapshot overrides write");

    wr(4'd0, 8'h10);
    chk("R2 lock output", {63'd0, time_lock}, 64'd1);
    cmd(4'hE, 1'b0, 4'd0, 8'h00);
    rd(4'd1, "R9 flags kept when locked");

    wr(4'd0, 8'h00);
    wr(4'd2, 8'h07); wr(4'd3, 8'h08); wr(4'd9, 8'h33);
    cmd(4'hE, 1'b0, 4'd0, 8'h00);
    rd(4'd1, "R8 flags cleared on load");
    rd(4'd2, "R8 fields kept after load");

    rd(4'd12, "R10 unmapped location");
    rd(4'd15, "R10 unmapped location high");
    cmd(4'h5, 1'b0, 4'd0, 8'h00);
    rd(4'd2, "R10 unknown command ignored");

    cal_live = 64'h0101_0101_0101_0101;
    cmd(4'hF, 1'b1, 4'd2, 8'hEE);
    rd(4'd2, "R11 command wins over write");
    cmd(4'h3, 1'b1, 4'd0, 8'h1D);
    rd(4'd0, "R11 write dropped with command");

    repeat (3) @(negedge clk);
    chk("R10 all reads returned", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule